// File: doc/BRIEF.md
# Audio Serial Port Clock and Frame Generator

This block produces, or receives, the two timing signals of one digital audio serial port: the bit clock and the left/right frame clock. Everything runs in the master-clock domain. In full master mode the block divides the master clock to make both signals and drives both pins. In partial-master mode it drives only the bit clock and follows a frame clock supplied from outside. In slave mode both pins are inputs, and the block only passes the external timing through to the rest of the port.

The bit clock and the frame clock come from two separate dividers. The bit-clock divider restarts at every frame edge. When a frame does not hold a whole number of bit-clock periods, the last bit-clock half-period of that frame is cut short. The divide settings are taken in only at frame edges and on entry to a mode, so a change made in the middle of a frame never produces a runt pulse.

The mode controller has four states:
- `ST_LOAD` is a one-cycle reload state. It is entered from reset and on any change of mode. It loads the settings and clears both dividers.
- `ST_MASTER` drives both pins.
- `ST_PARTIAL` drives the bit clock and follows the external frame clock.
- `ST_SLAVE` drives neither pin.

Transitions:
- From `ST_LOAD` the controller goes to the mode that the inputs request.
- From any other state it stays while the requested mode is unchanged. Otherwise it goes back to `ST_LOAD`.

Top module: `aud_clkgen`

## Requirements
- R1: With `master_en`=1 and `frame_oe`=1 (full master), `bclk_oe` and `frm_oe_o` are both 1 and `frm_out` equals `frm_act`.
- R2: With `master_en`=0 (slave), `bclk_oe` and `frm_oe_o` are both 0 whatever `frame_oe` is, and `bclk_act` equals `bclk_in` XOR `bclk_inv`.
- R3: With `master_en`=1 and `frame_oe`=0 (partial master), `bclk_oe` is 1 and `frm_oe_o` is 0.
- R4: In full master mode `frm_act` toggles every H master-clock cycles, giving a 50% duty frame. H is the latched `fs_half` value, and a value of 0 is treated as 1.
- R5: The internal bit clock toggles every R master-clock cycles, with R = 2^min(`bdiv_sel`,5). Codes 0..5 give 1, 2, 4, 8, 16 and 32, and codes 6 and 7 both give 32.
- R6: In the same clock edge that changes `frm_act`, the bit-clock divider restarts. The bit clock returns to its uninverted low phase and counts R cycles afresh, so the last half-period of a frame may be shorter than R.
- R7: `bclk_out` is the internal bit clock XOR `bclk_inv`. In both driving modes `bclk_act` equals `bclk_out`.
- R8: In slave and partial-master modes, `frm_in` passes through a two-flip-flop synchroniser. A change of `frm_in` appears on `frm_act` at the third rising master-clock edge after it.
- R9: `bdiv_sel` and `fs_half` are sampled only at frame edges and in `ST_LOAD`. The whole frame that follows uses the sampled values.
- R10: During reset, `bclk_oe`, `frm_oe_o` and `frm_act` are 0 and the internal bit clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | 1 selects a driving mode, 0 selects slave |
| frame_oe | input | 1 | With master_en=1, 1 drives the frame pin and 0 receives it |
| bdiv_sel | input | 3 | Bit-clock divide code |
| fs_half | input | FS_W | Frame half-period in master-clock cycles |
| bclk_inv | input | 1 | Inverts the bit clock |
| bclk_in | input | 1 | Bit clock from the pin in slave mode |
| frm_in | input | 1 | Frame clock from the pin in slave and partial modes |
| bclk_out | output | 1 | Bit clock driven to the pin |
| bclk_oe | output | 1 | Output enable for the bit-clock pin |
| frm_out | output | 1 | Frame clock driven to the pin |
| frm_oe_o | output | 1 | Output enable for the frame pin |
| bclk_act | output | 1 | Bit clock used by the port's shifters |
| frm_act | output | 1 | Frame clock used by the port's shifters |

## Verification
The hardest situation to reach from the ports is a divide setting that changes partway through a frame while a frame edge cuts a bit-clock half-period short. The new setting must wait for the edge, and the short half-period must end exactly on it. The stimulus changes `bdiv_sel`, `fs_half` and `bclk_inv` at random cycles, and it uses frame lengths that are not multiples of the bit-clock ratio, plus a directed 10/4 case. The bench latches its expected H and R only at the frame edges it observes, so a setting taken in early shows up as a wrong half-period. In partial mode the bench produces its own irregular frame edges, so the divider restarts at points the internal counters never choose.

// File: rtl/aud_clk_pkg.sv
package aud_clk_pkg;
    typedef enum logic [1:0] {
        ST_LOAD    = 2'd0,
        ST_MASTER  = 2'd1,
        ST_PARTIAL = 2'd2,
        ST_SLAVE   = 2'd3
    } clk_state_e;
endpackage

// File: rtl/aud_frame_sync.sv
module aud_frame_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level_o,
    output logic edge_o
);
    logic [STAGES:0] chain;

    for (genvar i = 0; i <= STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign level_o = chain[STAGES-1];
    assign edge_o  = chain[STAGES-1] ^ chain[STAGES];
endmodule

// File: rtl/aud_bit_div.sv
module aud_bit_div #(
    parameter int RATIO_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               run,
    input  logic [RATIO_W-1:0] ratio,
    output logic               bclk_o
);
    logic [RATIO_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            bclk_o <= 1'b0;
        end else if (clear) begin
            cnt    <= '0;
            bclk_o <= 1'b0;
        end else if (run) begin
            if (cnt == ratio - RATIO_W'(1)) begin
                cnt    <= '0;
                bclk_o <= ~bclk_o;
            end else begin
                cnt <= cnt + RATIO_W'(1);
            end
        end
    end

    AST_BIT_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < ratio));  // R5
endmodule

// File: rtl/aud_frame_div.sv
module aud_frame_div #(
    parameter int FS_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            gen,
    input  logic [FS_W-1:0] half,
    input  logic            ext_lvl,
    output logic            frm_o,
    output logic            edge_o
);
    logic [FS_W-1:0] cnt;

    assign edge_o = gen && (cnt == half - FS_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            frm_o <= 1'b0;
        end else if (clear) begin
            cnt   <= '0;
            frm_o <= 1'b0;
        end else if (gen) begin
            if (edge_o) begin
                cnt   <= '0;
                frm_o <= ~frm_o;
            end else begin
                cnt <= cnt + FS_W'(1);
            end
        end else begin
            cnt   <= '0;
            frm_o <= ext_lvl;
        end
    end

    AST_FRAME_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> (frm_o != $past(frm_o)));  // R4
    AST_HALF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        gen |-> (cnt < half));  // R4
endmodule

// File: rtl/aud_clkgen.sv
module aud_clkgen
    import aud_clk_pkg::*;
#(
    parameter int FS_W        = 10,
    parameter int MAX_SHIFT   = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            master_en,
    input  logic            frame_oe,
    input  logic [2:0]      bdiv_sel,
    input  logic [FS_W-1:0] fs_half,
    input  logic            bclk_inv,
    input  logic            bclk_in,
    input  logic            frm_in,
    output logic            bclk_out,
    output logic            bclk_oe,
    output logic            frm_out,
    output logic            frm_oe_o,
    output logic            bclk_act,
    output logic            frm_act
);
    localparam int RATIO_W = MAX_SHIFT + 1;

    clk_state_e state_q, state_nxt, want;
    logic [RATIO_W-1:0] ratio_q;
    logic [FS_W-1:0]    half_q;
    logic               gen_edge, ext_edge, ext_lvl, frame_edge;
    logic               bclk_raw, frm_q;
    logic [1:0]         age_q;

    function automatic logic [RATIO_W-1:0] ratio_of(input logic [2:0] sel);
        int sh;
        sh = (int'(sel) > MAX_SHIFT) ? MAX_SHIFT : int'(sel);
        return RATIO_W'(1) << sh;
    endfunction

    always_comb begin
        if (!master_en)    want = ST_SLAVE;
        else if (frame_oe) want = ST_MASTER;
        else               want = ST_PARTIAL;
    end

    always_comb begin
        unique case (state_q)
            ST_LOAD:    state_nxt = want;
            ST_MASTER:  state_nxt = (want == ST_MASTER)  ? ST_MASTER  : ST_LOAD;
            ST_PARTIAL: state_nxt = (want == ST_PARTIAL) ? ST_PARTIAL : ST_LOAD;
            ST_SLAVE:   state_nxt = (want == ST_SLAVE)   ? ST_SLAVE   : ST_LOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_nxt;
    end

    always_comb begin
        unique case (state_q)
            ST_LOAD: begin
                bclk_oe = 1'b0; frm_oe_o = 1'b0; frame_edge = 1'b0;
            end
            ST_MASTER: begin
                bclk_oe = 1'b1; frm_oe_o = 1'b1; frame_edge = gen_edge;
            end
            ST_PARTIAL: begin
                bclk_oe = 1'b1; frm_oe_o = 1'b0; frame_edge = ext_edge;
            end
            ST_SLAVE: begin
                bclk_oe = 1'b0; frm_oe_o = 1'b0; frame_edge = ext_edge;
            end
        endcase
        bclk_out = bclk_raw ^ bclk_inv;
        bclk_act = bclk_oe ? bclk_out : (bclk_in ^ bclk_inv);
        frm_out  = frm_q;
        frm_act  = frm_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ratio_q <= RATIO_W'(1);
            half_q  <= FS_W'(1);
        end else if (state_q == ST_LOAD || frame_edge) begin
            ratio_q <= ratio_of(bdiv_sel);
            half_q  <= (fs_half == '0) ? FS_W'(1) : fs_half;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             age_q <= 2'd0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    aud_frame_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(frm_in),
        .level_o(ext_lvl), .edge_o(ext_edge)
    );

    aud_frame_div #(.FS_W(FS_W)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .clear(state_q == ST_LOAD),
        .gen(state_q == ST_MASTER),
        .half(half_q), .ext_lvl(ext_lvl),
        .frm_o(frm_q), .edge_o(gen_edge)
    );

    aud_bit_div #(.RATIO_W(RATIO_W)) u_bit (
        .clk(clk), .rst_n(rst_n),
        .clear(state_q == ST_LOAD || frame_edge),
        .run(state_q == ST_MASTER || state_q == ST_PARTIAL),
        .ratio(ratio_q), .bclk_o(bclk_raw)
    );

    AST_RESTART_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_edge |=> !bclk_raw);  // R6
    AST_MASTER_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && master_en && frame_oe && $past(master_en) && $past(frame_oe)
         && $past(master_en, 2) && $past(frame_oe, 2)) |-> (bclk_oe && frm_oe_o));  // R1
    AST_PARTIAL_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && master_en && !frame_oe && $past(master_en) && !$past(frame_oe)
         && $past(master_en, 2) && !$past(frame_oe, 2)) |-> (bclk_oe && !frm_oe_o));  // R3
    AST_SLAVE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_en && !$past(master_en)) |-> (!bclk_oe && !frm_oe_o));  // R2
endmodule

// File: tb/aud_clkgen_test.sv
module aud_clkgen_test;
    localparam int FS_W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_en = 1'b0, frame_oe = 1'b0, bclk_inv = 1'b0, bclk_in = 1'b0, frm_in = 1'b0;
    logic [2:0] bdiv_sel = 3'd0;
    logic [FS_W-1:0] fs_half = '0;
    logic bclk_out, bclk_oe, frm_out, frm_oe_o, bclk_act, frm_act;

    int total = 0, bad = 0, cyc = 0;
    int last_frm = 0, last_evt = 0, exp_h = 1, exp_r = 1;
    int settle = 0, gap = 5, drive_cyc = 0;
    bit armed = 0, pend = 0, done = 0;
    logic prev_frm = 1'b0, prev_raw = 1'b0;

    always #5 clk = ~clk;

    aud_clkgen #(.FS_W(FS_W)) uut (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .frame_oe(frame_oe),
        .bdiv_sel(bdiv_sel), .fs_half(fs_half), .bclk_inv(bclk_inv),
        .bclk_in(bclk_in), .frm_in(frm_in),
        .bclk_out(bclk_out), .bclk_oe(bclk_oe), .frm_out(frm_out),
        .frm_oe_o(frm_oe_o), .bclk_act(bclk_act), .frm_act(frm_act)
    );

    function automatic int f_ratio(input logic [2:0] s);
        return 1 << ((s > 3'd5) ? 5 : int'(s));
    endfunction

    function automatic int f_half(input logic [FS_W-1:0] v);
        return (v == '0) ? 1 : int'(v);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic enter(input int mode);
        master_en = (mode != 2);
        frame_oe  = (mode == 0);
        settle = 4; armed = 0; pend = 0; gap = 5;
    endtask

    task automatic tick(input int mode, input bit rnd);
        logic raw;
        @(negedge clk);
        cyc++;
        raw = bclk_out ^ bclk_inv;
        if (settle > 0) settle--;
        else begin
            if (mode == 0) begin
                check(bclk_oe && frm_oe_o, "R1", "both pins driven", {bclk_oe, frm_oe_o}, 3);
                check(frm_out == frm_act, "R1", "frame pin", frm_out, frm_act);
                check(bclk_act == bclk_out, "R7", "active bclk", bclk_act, bclk_out);
            end else if (mode == 1) begin
                check(bclk_oe && !frm_oe_o, "R3", "partial pins", {bclk_oe, frm_oe_o}, 2);
                check(bclk_act == bclk_out, "R7", "active bclk", bclk_act, bclk_out);
            end else begin
                check(!bclk_oe && !frm_oe_o, "R2", "slave pins", {bclk_oe, frm_oe_o}, 0);
                check(bclk_act == (bclk_in ^ bclk_inv), "R2", "slave bclk",
                      bclk_act, bclk_in ^ bclk_inv);
            end
            if (frm_act != prev_frm) begin
                if (mode != 2) begin
                    check(raw == 1'b0, "R6", "bclk phase at frame edge", raw, 0);
                    check(bclk_out == bclk_inv, "R7", "inverted idle level", bclk_out, bclk_inv);
                end
                if (mode == 0 && armed)
                    check(cyc - last_frm == exp_h, "R4 R9", "frame half-period",
                          cyc - last_frm, exp_h);
                if (mode != 0 && pend) begin
                    check(cyc - drive_cyc == 3, "R8", "sync latency", cyc - drive_cyc, 3);
                    pend = 0;
                end
                exp_h = f_half(fs_half);
                exp_r = f_ratio(bdiv_sel);
                last_frm = cyc; last_evt = cyc; armed = 1;
            end else if (mode != 2 && raw != prev_raw) begin
                if (armed)
                    check(cyc - last_evt == exp_r, "R5 R9", "bclk half-period",
                          cyc - last_evt, exp_r);
                last_evt = cyc;
            end
        end
        prev_frm = frm_act;
        prev_raw = raw;
        if (rnd) begin
            if ($urandom_range(0, 15) == 0) bdiv_sel = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 15) == 0) fs_half = FS_W'($urandom_range(0, 70));
            if ($urandom_range(0, 31) == 0) bclk_inv = ~bclk_inv;
        end
        if (mode == 2) begin
            bclk_in  = 1'($urandom_range(0, 1));
            frame_oe = 1'($urandom_range(0, 1));
        end
        if (mode != 0 && settle == 0) begin
            if (gap == 0) begin
                frm_in = ~frm_in; drive_cyc = cyc; pend = 1;
                gap = $urandom_range(4, 60);
            end else gap--;
        end
    endtask

    task automatic run(input int mode, input bit rnd, input int n);
        for (int i = 0; i < n; i++) tick(mode, rnd);
    endtask

    initial begin
        void'($urandom(32'd4321));
        // R10: reset state
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!bclk_oe && !frm_oe_o, "R10", "oe in reset", {bclk_oe, frm_oe_o}, 0);
            check(frm_act == 1'b0, "R10", "frame in reset", frm_act, 0);
            check(bclk_out == bclk_inv, "R10", "bclk low in reset", bclk_out, bclk_inv);
        end
        master_en = 1'b1; frame_oe = 1'b1;
        rst_n = 1'b1;
        // R6: 10-cycle half frame with ratio 4 -> short last pulse
        fs_half = FS_W'(10); bdiv_sel = 3'd2; enter(0); run(0, 0, 200);
        // R4: zero half count treated as 1
        fs_half = '0; bdiv_sel = 3'd0; enter(0); run(0, 0, 100);
        // R5: codes 7 and 6 both divide by 32
        fs_half = FS_W'(80); bdiv_sel = 3'd7; bclk_inv = 1'b1; enter(0); run(0, 0, 400);
        fs_half = FS_W'(70); bdiv_sel = 3'd6; enter(0); run(0, 0, 300);
        fs_half = FS_W'(24); bdiv_sel = 3'd3; bclk_inv = 1'b0;
        enter(0); run(0, 1, 5000);
        enter(1); run(1, 1, 5000);
        enter(2); run(2, 1, 3000);
        enter(0); run(0, 1, 2000);
        enter(1); run(1, 1, 2000);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(1_500_000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 18000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule